// File: doc/BRIEF.md
# Four-Point Ternary Approximate Cosine Transform

This block turns a vector of four signed samples into four transform coefficients that approximate a 4-point type-II cosine transform. Every coefficient of its integer kernel is -1, 0 or +1, so the datapath has no multipliers and no shifters. A two-level butterfly computes the result with six adders and subtractors.

The kernel rows are orthogonal to each other, but they do not share one norm. The per-row normalisation (one half for the even rows, one over root two for the odd rows) is left to the quantiser that follows. That scaling therefore costs nothing in this block. A new vector may arrive on every clock. The coefficients come out of one register stage, with a valid strobe that tracks the input strobe. There is no stall path.

Top module: `approx_dct4`

## Requirements
- R1: A synchronous active-high reset `rst` clears `out_valid` and sets all four coefficient outputs to zero on the next rising clock edge.
- R2: `out_valid` equals the value `in_valid` had one rising edge earlier, whenever reset is not asserted.
- R3: When a vector is accepted, the `y0` that follows one cycle later equals x0 + x1 + x2 + x3.
- R4: When a vector is accepted, the `y1` that follows one cycle later equals x0 - x3.
- R5: When a vector is accepted, the `y2` that follows one cycle later equals x0 - x1 - x2 + x3.
- R6: When a vector is accepted, the `y3` that follows one cycle later equals x1 - x2.
- R7: Inputs are two's-complement with IN_W bits. Outputs are two's-complement with IN_W+2 bits. Every result is exact, with no wrap, for all inputs, including all samples at the most negative value (y0 = -512 at IN_W=8) and mixed extremes.
- R8: While `in_valid` is low, the sample inputs have no effect. All four coefficient outputs keep their last values.
- R9: A vector is accepted on every cycle that `in_valid` is high. Back-to-back vectors each produce their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the sample vector as present |
| x0 | input | IN_W | Sample 0, signed |
| x1 | input | IN_W | Sample 1, signed |
| x2 | input | IN_W | Sample 2, signed |
| x3 | input | IN_W | Sample 3, signed |
| out_valid | output | 1 | Marks the coefficients as fresh |
| y0 | output | IN_W+2 | DC coefficient, signed |
| y1 | output | IN_W+2 | First odd coefficient, signed |
| y2 | output | IN_W+2 | Second even coefficient, signed |
| y3 | output | IN_W+2 | Second odd coefficient, signed |

## Verification
The bench builds the block with the default IN_W of 8. At that width all 256 levels of each sample can be reached, including the most negative one. The all-minimum vector produces the largest-magnitude DC result, -512, which sits exactly at the bottom of the 10-bit output range. Alternating extreme patterns push the second even coefficient to its bounds. A long stretch of random vectors with random gaps in the strobe covers back-to-back acceptance and the hold behaviour on idle cycles.

// File: rtl/approx_dct4.sv
module approx_dct4 #(
  parameter int IN_W = 8,
  localparam int OUT_W = IN_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  x0,
  input  logic signed [IN_W-1:0]  x1,
  input  logic signed [IN_W-1:0]  x2,
  input  logic signed [IN_W-1:0]  x3,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] y0,
  output logic signed [OUT_W-1:0] y1,
  output logic signed [OUT_W-1:0] y2,
  output logic signed [OUT_W-1:0] y3
);

  logic signed [OUT_W-1:0] e0, e1, e2, e3;
  logic signed [OUT_W-1:0] sum_ends, sum_mids, dif_ends, dif_mids;

  assign e0 = OUT_W'(x0);
  assign e1 = OUT_W'(x1);
  assign e2 = OUT_W'(x2);
  assign e3 = OUT_W'(x3);

  // first butterfly level: four adders
  assign sum_ends = e0 + e3;
  assign dif_ends = e0 - e3;
  assign sum_mids = e1 + e2;
  assign dif_mids = e1 - e2;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      y0 <= '0;
      y1 <= '0;
      y2 <= '0;
      y3 <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        // second level: two adders; odd rows pass straight through
        y0 <= sum_ends + sum_mids;
        y2 <= sum_ends - sum_mids;
        y1 <= dif_ends;
        y3 <= dif_mids;
      end
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && y0 == '0 && y1 == '0 && y2 == '0 && y3 == '0));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_dc_row_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (32'(y0) == $past(32'(x0) + 32'(x1) + 32'(x2) + 32'(x3))));

  assert_odd_row_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (32'(y1) == $past(32'(x0) - 32'(x3))));

  assert_even_row_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (32'(y2) == $past(32'(x0) - 32'(x1) - 32'(x2) + 32'(x3))));

  assert_mid_row_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (32'(y3) == $past(32'(x1) - 32'(x2))));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(y0) && $stable(y1) && $stable(y2) && $stable(y3)));

endmodule

// File: tb/approx_dct4_tb.sv
module approx_dct4_tb;
  localparam int IN_W = 8;
  localparam int OUT_W = IN_W + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] x0 = '0, x1 = '0, x2 = '0, x3 = '0;
  logic out_valid;
  logic signed [OUT_W-1:0] y0, y1, y2, y3;

  int errors = 0;
  int checks = 0;
  int ev = 0;
  int ey [4] = '{0, 0, 0, 0};

  always #4 clk = ~clk;

  approx_dct4 #(.IN_W(IN_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .x0(x0), .x1(x1), .x2(x2), .x3(x3),
    .out_valid(out_valid), .y0(y0), .y1(y1), .y2(y2), .y3(y3)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit v, input int a, input int b,
                      input int c, input int d, input string tag);
    @(negedge clk);
    rst = r; in_valid = v;
    x0 = IN_W'(a); x1 = IN_W'(b); x2 = IN_W'(c); x3 = IN_W'(d);
    if (r) begin
      ev = 0; ey = '{0, 0, 0, 0};
    end else begin
      ev = v ? 1 : 0;
      if (v) begin
        int s0 = int'(x0), s1 = int'(x1), s2 = int'(x2), s3 = int'(x3);
        ey[0] = s0 + s1 + s2 + s3;
        ey[1] = s0 - s3;
        ey[2] = s0 - s1 - s2 + s3;
        ey[3] = s1 - s2;
      end
    end
    @(negedge clk);
    chk({tag, " valid R2"}, int'(out_valid), ev);
    chk({tag, " y0 R3"}, int'(y0), ey[0]);
    chk({tag, " y1 R4"}, int'(y1), ey[1]);
    chk({tag, " y2 R5"}, int'(y2), ey[2]);
    chk({tag, " y3 R6"}, int'(y3), ey[3]);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(1, 0, 0, 0, 0, 0, "reset R1");
    step(1, 1, 5, 6, 7, 8, "reset ignores input R1");
    step(0, 1, 1, 2, 3, 4, "ramp");
    step(0, 1, 10, -3, 7, -20, "mixed");
    step(0, 1, 0, 0, 0, 0, "zero");
    step(0, 1, -128, -128, -128, -128, "all min R7");
    step(0, 1, 127, 127, 127, 127, "all max R7");
    step(0, 1, 127, -128, -128, 127, "even bound R7");
    step(0, 1, -128, 127, 127, -128, "even low R7");
    step(0, 1, 127, -128, 127, -128, "odd bound R7");
    step(0, 0, 99, -99, 50, 3, "idle hold R8");
    step(0, 0, -1, -1, -1, -1, "idle hold again R8");
    step(0, 1, 3, 1, 4, 1, "after idle R9");
    step(0, 1, 5, 9, 2, 6, "back to back R9");
    step(0, 1, -5, 3, -5, 8, "back to back R9");
    for (int i = 0; i < 2000; i++) begin
      step(0, ($urandom % 4) != 0,
           int'($urandom % 256) - 128, int'($urandom % 256) - 128,
           int'($urandom % 256) - 128, int'($urandom % 256) - 128, "random R9");
    end
    step(1, 1, 1, 1, 1, 1, "late reset R1");
    step(0, 1, 2, 4, 8, 16, "post reset");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule